// File: doc/BRIEF.md
# Expansion ROM Base Register and Address Decoder

This block keeps the expansion ROM base register of a PCI target's configuration space and uses it to claim memory reads aimed at the ROM. The host reaches the register through a configuration write strobe with per-lane byte enables and a read-data output that always shows the current value. The upper eight base bits are always writable. A separate window mask decides which of the lower base bits, 23 down to 11, the host may write, so it sets the ROM window size. A separate allow flag decides whether the ROM enable bit can ever be set.

On every address phase the block checks four things: the bus command, the ROM enable, the memory space enable from the command register, and the upper address bits. If all of them pass, it raises a one-cycle request for the bus logic to assert DEVSEL. Only a hard reset clears the register. No other reset or stop condition reaches this block, so the register keeps its value through them. The address phase is a plain strobe with no back-pressure, and the decoder always accepts it.

Top module: `rom_bar_decoder`

## Requirements
- R1: Register bits 31–24 store whatever the host writes to them, whatever the window mask and allow flag hold.
- R2: Register bit 11+i is writable only while win_mask[i] is 1. A bit whose mask bit is 0 reads back as 0, so writing all ones and reading back gives the window size.
- R3: Bits 10–1 always read as 0, and writes to them are ignored.
- R4: Bit 0, the ROM enable, can be set only while rom_allow is 1. While rom_allow is 0 it reads 0 and no access is ever claimed.
- R5: Byte enable b updates only bits 8b+7 down to 8b of the register. Lanes whose enable is 0 keep their value.
- R6: An access is claimed only when the ROM enable bit and mem_space_en are both 1.
- R7: Only the commands 4'b0110, 4'b1100 and 4'b1110 are claimed. Every other command, memory writes included, is never claimed.
- R8: An address matches when it equals the stored base on bits 31–24 and on every bit 23–11 whose mask bit is 1. All other bits are don't-care, so the window spans 2^(lowest writable bit) bytes.
- R9: devsel_req is high during the cycle after a qualifying address strobe, for exactly one cycle per strobe.
- R10: While hard reset is active and after it ends, the register reads 0 and devsel_req is low.
- R11: A write changes the register on the clock edge that samples the strobe. An address phase sampled on that same edge is decoded against the old value. Later phases use the new value.
- R12: Without a configuration write, the stored register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_hard_n | input | 1 | Hard reset, active low, asynchronous |
| cfg_we | input | 1 | Configuration write strobe for this register |
| cfg_be | input | 4 | Byte-lane enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Masked register value |
| win_mask | input | 13 | Writability of base bits 23–11 (bit i covers bit 11+i) |
| rom_allow | input | 1 | Permits setting the ROM enable bit |
| mem_space_en | input | 1 | Memory space enable from the command register |
| ap_valid | input | 1 | Address phase strobe |
| ap_cmd | input | 4 | Bus command of the address phase |
| ap_addr | input | 21 | Address bits 31–11 of the address phase |
| devsel_req | output | 1 | Registered request to claim the access |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a window field from bit 11 to bit 23, and an always-writable field from bit 24. This covers the whole range of window sizes. With a full mask the window is 2 KB. With only bit 23 writable it is 8 MB. With an empty mask it is 16 MB. The allow flag is also cleared, which blocks the enable bit. A behavioural model compares read data and devsel_req on every cycle. That comparison covers partial byte-lane writes, a write that lands in the same cycle as an address phase, the command filter, and a reset applied mid-run.

// File: rtl/rom_bar_pkg.sv
package rom_bar_pkg;
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;

  function automatic logic is_rom_read(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RD_MULT) ||
           (cmd == CMD_MEM_RD_LINE);
  endfunction
endpackage

// File: rtl/rom_bar_reg.sv
module rom_bar_reg #(
  parameter int AW = 32,
  parameter int LO = 11,
  parameter int HI = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW/8-1:0] be,
  input  logic [AW-1:0]   wdata,
  input  logic [HI-LO-1:0] win_mask,
  input  logic            allow,
  output logic [AW-1:0]   rdata,
  output logic [AW-1:LO]  base_o,
  output logic [AW-1:LO]  cmp_mask_o,
  output logic            en_o
);
  localparam int NB = AW / 8;

  logic [AW-1:0] wmask;
  logic [AW-1:0] bar_q;

  always_comb begin
    for (int i = 0; i < AW; i++) begin
      if (i >= HI)      wmask[i] = 1'b1;
      else if (i >= LO) wmask[i] = win_mask[i-LO];
      else if (i == 0)  wmask[i] = allow;
      else              wmask[i] = 1'b0;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bar_q[8*b +: 8] <= '0;
      else if (we && be[b])
        bar_q[8*b +: 8] <= wdata[8*b +: 8] & wmask[8*b +: 8];
    end
  end

  assign rdata      = bar_q & wmask;
  assign base_o     = bar_q[AW-1:LO];
  assign cmp_mask_o = wmask[AW-1:LO];
  assign en_o       = bar_q[0] & allow;

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> bar_q == $past(bar_q));
  p_en_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !allow) |=> !bar_q[0]);
endmodule

// File: rtl/rom_bar_match.sv
module rom_bar_match
  import rom_bar_pkg::*;
#(
  parameter int AW = 32,
  parameter int LO = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic [3:0]     cmd,
  input  logic [AW-1:LO] addr,
  input  logic [AW-1:LO] base,
  input  logic [AW-1:LO] cmp_mask,
  input  logic           rom_en,
  input  logic           mem_en,
  output logic           hit_q
);
  logic addr_ok, hit_d;

  assign addr_ok = ((addr ^ base) & cmp_mask) == '0;
  assign hit_d   = strobe && mem_en && rom_en && is_rom_read(cmd) && addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(strobe));
  p_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(mem_en && rom_en));
  p_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(cmd == 4'b0110 || cmd == 4'b1100 || cmd == 4'b1110));
endmodule

// File: rtl/rom_bar_decoder.sv
module rom_bar_decoder #(
  parameter int AW = 32,
  parameter int LO = 11,
  parameter int HI = 24,
  localparam int NB = AW / 8,
  localparam int MW = HI - LO
) (
  input  logic          clk,
  input  logic          rst_hard_n,
  input  logic          cfg_we,
  input  logic [NB-1:0] cfg_be,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic [MW-1:0] win_mask,
  input  logic          rom_allow,
  input  logic          mem_space_en,
  input  logic          ap_valid,
  input  logic [3:0]    ap_cmd,
  input  logic [AW-1:LO] ap_addr,
  output logic          devsel_req
);
  logic [AW-1:LO] base, cmp_mask;
  logic           rom_en;

  rom_bar_reg #(.AW(AW), .LO(LO), .HI(HI)) u_reg (
    .clk(clk), .rst_n(rst_hard_n), .we(cfg_we), .be(cfg_be),
    .wdata(cfg_wdata), .win_mask(win_mask), .allow(rom_allow),
    .rdata(cfg_rdata), .base_o(base), .cmp_mask_o(cmp_mask), .en_o(rom_en)
  );

  rom_bar_match #(.AW(AW), .LO(LO)) u_match (
    .clk(clk), .rst_n(rst_hard_n), .strobe(ap_valid), .cmd(ap_cmd),
    .addr(ap_addr), .base(base), .cmp_mask(cmp_mask), .rom_en(rom_en),
    .mem_en(mem_space_en), .hit_q(devsel_req)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_hard_n |-> !devsel_req && cfg_rdata == '0);
endmodule

// File: tb/rom_bar_decoder_bench.sv
`timescale 1ns/1ps
module rom_bar_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [3:0]  be = 0;
  logic [31:0] wd = 0;
  logic [31:0] rd;
  logic [12:0] wmask = 0;
  logic        allow = 0;
  logic        mem_en = 0;
  logic        apv = 0;
  logic [3:0]  cmd = 0;
  logic [20:0] addr = 0;
  logic        dev;

  always #2.5 clk = ~clk;

  rom_bar_decoder u_rom_bar_decoder (
    .clk(clk), .rst_hard_n(rst_n), .cfg_we(we), .cfg_be(be), .cfg_wdata(wd),
    .cfg_rdata(rd), .win_mask(wmask), .rom_allow(allow), .mem_space_en(mem_en),
    .ap_valid(apv), .ap_cmd(cmd), .ap_addr(addr), .devsel_req(dev)
  );

  int    tests = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R10";
  logic [31:0] ref_store = 0;
  logic        exp_dev = 0;

  function automatic logic [31:0] full_mask(input logic [12:0] w, input logic a);
    return 32'hFF00_0000 | ({19'b0, w} << 11) | {31'b0, a};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_store = 0;
      exp_dev   = 0;
    end else begin
      logic [31:0] m;
      logic        cmd_ok;
      m = full_mask(wmask, allow);
      cmd_ok = (cmd == 4'h6) || (cmd == 4'hC) || (cmd == 4'hE);
      exp_dev = apv && mem_en && ref_store[0] && allow && cmd_ok &&
                (((({addr, 11'b0}) ^ ref_store) & m & 32'hFFFF_F800) == 0);
      if (we)
        for (int b = 0; b < 4; b++)
          if (be[b]) ref_store[8*b +: 8] = wd[8*b +: 8] & m[8*b +: 8];
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, "rdata", rd, ref_store & full_mask(wmask, allow));
    chk(cur_req, "devsel_req", {31'b0, dev}, {31'b0, exp_dev});
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      we = 0; apv = 0;
    end
  endtask

  task automatic wr(input logic [3:0] e, input logic [31:0] d);
    @(negedge clk); #1;
    we = 1; be = e; wd = d; apv = 0;
    idle(1);
  endtask

  task automatic ap(input logic [3:0] c, input logic [31:0] a);
    @(negedge clk); #1;
    apv = 1; cmd = c; addr = a[31:11]; we = 0;
    idle(2);
  endtask

  initial begin
    cur_req = "R10";
    idle(3);
    chk("R10", "reset rdata", rd, 32'h0);
    chk("R10", "reset devsel", {31'b0, dev}, 32'h0);
    @(negedge clk); #1; rst_n = 1; mem_en = 1;
    wmask = 13'h1FFF; allow = 1;

    cur_req = "R2"; wr(4'hF, 32'hFFFF_FFFF);
    chk("R3", "sizing readback", rd, 32'hFFFF_F801);
    cur_req = "R1"; wr(4'hF, 32'hA000_0001);
    cur_req = "R8"; ap(4'h6, 32'hA000_07FC); ap(4'h6, 32'hA000_0800);
    ap(4'h6, 32'hB000_0000);
    cur_req = "R7"; ap(4'h7, 32'hA000_0000); ap(4'hC, 32'hA000_0000);
    ap(4'hE, 32'hA000_0000); ap(4'h2, 32'hA000_0000); ap(4'hF, 32'hA000_0000);
    cur_req = "R6"; mem_en = 0; ap(4'h6, 32'hA000_0000); mem_en = 1;
    wr(4'h1, 32'h0); ap(4'h6, 32'hA000_0000);
    cur_req = "R9";
    @(negedge clk); #1; apv = 1; cmd = 4'h6; addr = 21'h140000 >> 0;
    addr = 32'hA000_0000 >> 11;
    idle(1);
    wr(4'h1, 32'h1);
    @(negedge clk); #1; apv = 1; cmd = 4'h6; addr = 32'hA000_0000 >> 11;
    @(negedge clk); #1; apv = 1;
    idle(3);

    cur_req = "R2"; wmask = 13'h1000;
    wr(4'hF, 32'hFFFF_FFFF);
    chk("R2", "narrow sizing", rd, 32'hFF80_0001);
    cur_req = "R8"; wr(4'hF, 32'hA080_0001);
    ap(4'h6, 32'hA0FF_FFFC); ap(4'h6, 32'hA07F_FFFC); ap(4'h6, 32'hA180_0000);
    wmask = 13'h0000; ap(4'h6, 32'hA07F_FFFC);

    cur_req = "R4"; allow = 0; wmask = 13'h1000;
    wr(4'hF, 32'hFFFF_FFFF);
    chk("R4", "enable blocked", rd, 32'hFF80_0000);
    ap(4'h6, 32'hFF80_0000);
    allow = 1; ap(4'h6, 32'hFF80_0000);

    cur_req = "R5"; wmask = 13'h1FFF;
    wr(4'hF, 32'h1234_5801);
    wr(4'h8, 32'h55AA_AAAA);
    chk("R5", "lane 3 only", rd, 32'h5534_5801);
    wr(4'h6, 32'h00FF_FF00);
    chk("R5", "lanes 1 2", rd, 32'h55FF_F801);

    cur_req = "R11"; wr(4'hF, 32'hC000_0001);
    @(negedge clk); #1;
    we = 1; be = 4'hF; wd = 32'hD000_0001;
    apv = 1; cmd = 4'h6; addr = 32'hD000_0000 >> 11;
    @(negedge clk); #1; we = 0;
    idle(2);

    cur_req = "R12";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      we = 0; be = 4'(i); wd = 32'h9E37_79B9 * i;
      apv = i[0]; cmd = 4'(i * 3); addr = 21'(32'hD000_0000 >> 11) ^ 21'(i % 3);
    end
    idle(1);
    chk("R12", "held value", rd, 32'hD000_0001);

    cur_req = "R10";
    @(negedge clk); #1; apv = 1; cmd = 4'h6; rst_n = 0;
    idle(2);
    chk("R10", "mid reset rdata", rd, 32'h0);
    chk("R10", "mid reset devsel", {31'b0, dev}, 32'h0);
    @(negedge clk); #1; rst_n = 1;
    ap(4'h6, 32'hD000_0000);
    idle(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule